// File: doc/BRIEF.md
# Cycle-Stealing DMA Sequencer with Load Mode

This block decides, one machine cycle at a time, whether the next eight-clock slot goes to the processor (an opcode fetch or an execute cycle) or to a single-byte DMA transfer. Two active-low request lines ask for device-to-memory and memory-to-device transfers. A request is sampled only at the last clock of a machine cycle and is served in the gap between an execute cycle and the next fetch. The processor therefore loses slots but never has to handle an interrupt for a transfer.

The transfer address is the processor's own 16-bit pointer register zero, which the processor can also load. The sequencer adds one to that register after every byte it moves. With the clear and wait controls both held active, the block is in load mode. Fetching stops, only device-to-memory transfers run, and each request stores the next byte at the next address. Because a reset leaves the pointer at zero, a keypad or a set of switches can fill memory from address zero without any boot program.

Top module: `cycle_steal_dma`

## Requirements
- R1: A machine cycle lasts exactly 8 clocks. `phase` counts 0 to 7 and `cycle_kind` changes only as phase 7 ends. The `cycle_kind` codes are 0 idle, 1 fetch, 2 execute, 3 DMA-in and 4 DMA-out.
- R2: The controls are active low. With clear active and wait inactive (reset mode), the pointer, the phase and the cycle kind go to zero (idle) on the next clock. With only wait active (pause), the phase, the kind and the pointer hold, and no strobe is given.
- R3: In run mode, a fetch cycle is always followed by an execute cycle, even if a request is pending. A request that is low at the end of an execute, idle or DMA cycle makes the next cycle a DMA cycle.
- R4: When both request lines are low at a decision point, the DMA-in cycle is chosen first. The DMA-out cycle follows it.
- R5: In a DMA-in cycle, `mem_we` is high for exactly one clock, at phase 5. At that clock `mem_addr` equals the pointer and `mem_wdata` equals `dev_wdata`.
- R6: In a DMA-out cycle, `dev_rvalid` is high for exactly one clock, at phase 5. At that clock `dev_rdata` equals `mem_rdata` read at `mem_addr`, which equals the pointer.
- R7: The pointer increases by one at the end of every DMA cycle. It wraps from 0xFFFF to 0x0000.
- R8: In load mode (clear and wait both active), no fetch, execute or DMA-out cycle starts, and the DMA-out request is ignored.
- R9: Successive load-mode requests after a reset write successive bytes to addresses 0, 1, 2 and so on.
- R10: A processor write to the pointer (`cpu_ptr_we`) takes effect on the next clock only during a fetch or execute cycle in run mode. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_n | input | 1 | Clear control, active low |
| wait_n | input | 1 | Wait control, active low |
| dma_in_req_n | input | 1 | Device-to-memory request, active low |
| dma_out_req_n | input | 1 | Memory-to-device request, active low |
| cpu_ptr_we | input | 1 | Processor write strobe for the pointer |
| cpu_ptr_wdata | input | 16 | Value the processor writes to the pointer |
| dev_wdata | input | 8 | Byte supplied by the device |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| ptr | output | 16 | Current pointer value |
| cycle_kind | output | 3 | Kind of the current machine cycle |
| phase | output | 3 | Clock position inside the machine cycle |
| mem_addr | output | 16 | Memory address during DMA cycles, zero otherwise |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte written to memory |
| dev_rdata | output | 8 | Byte delivered to the device |
| dev_rvalid | output | 1 | Data-valid strobe for `dev_rdata` |

## Verification
The hardest situation to reach from the ports is a pause that lands in the middle of a DMA cycle, after the request has already been granted but before the transfer strobe. The stimulus waits for phase 3 of a granted DMA-in cycle and then asserts wait alone for ten clocks. It checks that nothing moves during the pause and that exactly one write completes after release. A second hard case is a pointer write attempted during a DMA cycle. It is aimed at phase 1 of such a cycle, so only the port-visible increment should result.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_FETCH   = 3'd1,
    CYC_EXEC    = 3'd2,
    CYC_DMA_IN  = 3'd3,
    CYC_DMA_OUT = 3'd4
  } cyc_kind_e;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_PAUSE = 2'd1,
    MODE_RESET = 2'd2,
    MODE_LOAD  = 2'd3
  } run_mode_e;

  function automatic run_mode_e decode_mode(input logic clear_act, input logic wait_act);
    case ({clear_act, wait_act})
      2'b00:   return MODE_RUN;
      2'b01:   return MODE_PAUSE;
      2'b10:   return MODE_RESET;
      default: return MODE_LOAD;
    endcase
  endfunction

  function automatic logic is_dma(input cyc_kind_e k);
    return (k == CYC_DMA_IN) || (k == CYC_DMA_OUT);
  endfunction

  // Chooses the kind of the cycle that starts after the current one ends.
  function automatic cyc_kind_e pick_next(input cyc_kind_e cur, input run_mode_e mode,
                                          input logic in_pend, input logic out_pend);
    if (mode == MODE_LOAD) return in_pend ? CYC_DMA_IN : CYC_IDLE;
    if (cur == CYC_FETCH)  return CYC_EXEC;
    if (in_pend)           return CYC_DMA_IN;
    if (out_pend)          return CYC_DMA_OUT;
    return CYC_FETCH;
  endfunction

endpackage

// File: rtl/dma_phase_ctr.sv
module dma_phase_ctr
  import dma_pkg::*;
#(
  parameter int PHASES = 8,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  run_mode_e       mode,
  output logic [PH_W-1:0] phase,
  output logic            cycle_end
);
  localparam int LAST = PHASES - 1;

  logic advancing;
  assign advancing = (mode == MODE_RUN) || (mode == MODE_LOAD);
  assign cycle_end = advancing && (phase == LAST[PH_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (mode == MODE_RESET) phase <= '0;
    else if (cycle_end)         phase <= '0;
    else if (advancing)         phase <= phase + 1'b1;
  end

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == MODE_PAUSE) |-> phase == $past(phase)); // R2

  AST_PHASE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_end) |-> phase == '0); // R1

endmodule

// File: rtl/dma_cycle_sel.sv
module dma_cycle_sel
  import dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  run_mode_e mode,
  input  logic      cycle_end,
  input  logic      in_req_n,
  input  logic      out_req_n,
  output cyc_kind_e kind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 kind <= CYC_IDLE;
    else if (mode == MODE_RESET) kind <= CYC_IDLE;
    else if (cycle_end)         kind <= pick_next(kind, mode, !in_req_n, !out_req_n);
  end

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_end && mode == MODE_RUN && kind == CYC_FETCH) |-> kind == CYC_EXEC); // R3

  AST_IN_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_end && mode == MODE_RUN && kind != CYC_FETCH && !in_req_n) |-> kind == CYC_DMA_IN); // R4

  AST_LOAD_ONLY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_end && mode == MODE_LOAD) |-> (kind == CYC_IDLE || kind == CYC_DMA_IN)); // R8

  AST_KIND_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cycle_end && mode != MODE_RESET) |-> kind == $past(kind)); // R1

endmodule

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);
  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clear)   ptr <= '0;
    else if (step)    ptr <= next_ptr(ptr);
    else if (load_en) ptr <= load_val;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && !clear) |-> ptr == $past(ptr) + 1'b1); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!step && !clear && !load_en) |-> ptr == $past(ptr)); // R10

endmodule

// File: rtl/cycle_steal_dma.sv
module cycle_steal_dma
  import dma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PHASES     = 8,
  parameter int XFER_PHASE = 5,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_n,
  input  logic            wait_n,
  input  logic            dma_in_req_n,
  input  logic            dma_out_req_n,
  input  logic            cpu_ptr_we,
  input  logic [AW-1:0]   cpu_ptr_wdata,
  input  logic [DW-1:0]   dev_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   ptr,
  output logic [2:0]      cycle_kind,
  output logic [PH_W-1:0] phase,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   dev_rdata,
  output logic            dev_rvalid
);
  localparam logic [PH_W-1:0] XFER_AT = XFER_PHASE[PH_W-1:0];

  run_mode_e mode;
  cyc_kind_e kind;
  logic      cycle_end;
  logic      active;
  logic      at_xfer;
  logic      dma_now;
  logic      ptr_step;
  logic      ptr_clear;
  logic      cpu_accept;

  assign mode = decode_mode(!clear_n, !wait_n);

  dma_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase), .cycle_end(cycle_end)
  );

  dma_cycle_sel u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cycle_end(cycle_end),
    .in_req_n(dma_in_req_n), .out_req_n(dma_out_req_n), .kind(kind)
  );

  assign active     = (mode == MODE_RUN) || (mode == MODE_LOAD);
  assign at_xfer    = active && (phase == XFER_AT);
  assign dma_now    = is_dma(kind);
  assign ptr_step   = cycle_end && dma_now;
  assign ptr_clear  = (mode == MODE_RESET);
  assign cpu_accept = cpu_ptr_we && (mode == MODE_RUN) &&
                      (kind == CYC_FETCH || kind == CYC_EXEC);

  dma_ptr_reg #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(ptr_clear), .step(ptr_step),
    .load_en(cpu_accept), .load_val(cpu_ptr_wdata), .ptr(ptr)
  );

  assign cycle_kind = kind;
  assign mem_addr   = dma_now ? ptr : '0;
  assign mem_we     = (kind == CYC_DMA_IN) && at_xfer;
  assign mem_wdata  = dev_wdata;
  assign dev_rvalid = (kind == CYC_DMA_OUT) && at_xfer;
  assign dev_rdata  = dev_rvalid ? mem_rdata : '0;

  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5

  AST_RVALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rvalid |=> !dev_rvalid); // R6

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == MODE_RESET) |-> (ptr == '0 && phase == '0 && kind == CYC_IDLE)); // R2

  AST_CPU_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_ptr_we && dma_now && !cycle_end && mode != MODE_RESET) |-> ptr == $past(ptr)); // R10

  AST_NO_STROBE_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PAUSE) |-> (!mem_we && !dev_rvalid)); // R2

endmodule

// File: tb/test_cycle_steal_dma.sv
`timescale 1ns/1ps
module test_cycle_steal_dma;
  localparam logic [2:0] K_IDLE = 3'd0, K_FETCH = 3'd1, K_EXEC = 3'd2,
                         K_IN = 3'd3, K_OUT = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_n = 1'b0, wait_n = 1'b0;
  logic dma_in_req_n = 1'b1, dma_out_req_n = 1'b1;
  logic cpu_ptr_we = 1'b0;
  logic [15:0] cpu_ptr_wdata = '0;
  logic [7:0] dev_wdata = '0;
  logic [7:0] mem_rdata;
  logic [15:0] ptr, mem_addr;
  logic [2:0] cycle_kind, phase;
  logic mem_we, dev_rvalid;
  logic [7:0] mem_wdata, dev_rdata;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a ^ 8'h5A) + 8'd3;
  endfunction
  assign mem_rdata = pat(mem_addr[7:0]);

  cycle_steal_dma i_cycle_steal_dma (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .wait_n(wait_n),
    .dma_in_req_n(dma_in_req_n), .dma_out_req_n(dma_out_req_n),
    .cpu_ptr_we(cpu_ptr_we), .cpu_ptr_wdata(cpu_ptr_wdata),
    .dev_wdata(dev_wdata), .mem_rdata(mem_rdata), .ptr(ptr),
    .cycle_kind(cycle_kind), .phase(phase), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .dev_rdata(dev_rdata),
    .dev_rvalid(dev_rvalid)
  );

  typedef struct packed {logic is_wr; logic [15:0] addr; logic [7:0] data;} xfer_t;
  xfer_t exp_q[$];
  xfer_t item;
  logic [15:0] exp_ptr = '0;
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every transfer strobe must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && (mem_we || dev_rvalid)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6 unexpected strobe", {15'd0, mem_we, mem_addr}, 32'd0);
      end else begin
        item = exp_q.pop_front();
        check(item.is_wr == mem_we && item.addr == mem_addr &&
              item.data == (mem_we ? mem_wdata : dev_rdata),
              item.is_wr ? "R5 write" : "R6 read",
              {7'd0, mem_we, mem_addr, (mem_we ? mem_wdata : dev_rdata)},
              {7'd0, item.is_wr, item.addr, item.data});
      end
    end
  end

  task automatic wait_kind(input logic [2:0] k, input logic [2:0] ph);
    @(negedge clk);
    while (!(cycle_kind == k && phase == ph)) @(negedge clk);
  endtask

  task automatic dma_byte_in(input logic [7:0] d);
    dev_wdata = d;
    exp_q.push_back('{is_wr: 1'b1, addr: exp_ptr, data: d});
    exp_ptr++;
    dma_in_req_n = 1'b0;
    wait_kind(K_IN, 3'd0);
    dma_in_req_n = 1'b1;
    wait_kind(K_IN, 3'd7);
    @(negedge clk);
  endtask

  task automatic dma_byte_out();
    exp_q.push_back('{is_wr: 1'b0, addr: exp_ptr, data: pat(exp_ptr[7:0])});
    exp_ptr++;
    dma_out_req_n = 1'b0;
    wait_kind(K_OUT, 3'd0);
    dma_out_req_n = 1'b1;
    wait_kind(K_OUT, 3'd7);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int bad;
    logic [15:0] p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(ptr == 0 && cycle_kind == K_IDLE && phase == 0 && !mem_we && !dev_rvalid,
          "R2 reset state", {ptr, 13'd0, cycle_kind}, 32'd0);

    // Load mode (clear and wait active), out request held low and ignored.
    dma_out_req_n = 1'b0;
    dma_byte_in(8'h11);
    dma_byte_in(8'h22);
    dma_byte_in(8'h33);
    check(ptr == 16'd3, "R9 load fill from zero", ptr, 16'd3);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (cycle_kind != K_IDLE || dev_rvalid) bad++;
    end
    check(bad == 0, "R8 load mode idle only", bad, 0);
    dma_out_req_n = 1'b1;

    // Run mode.
    clear_n = 1'b1; wait_n = 1'b1;
    wait_kind(K_FETCH, 3'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (cycle_kind == K_FETCH);
    check(n == 8 && cycle_kind == K_EXEC && phase == 0, "R1 cycle length", n, 8);

    // Request raised during fetch still waits for the execute cycle.
    wait_kind(K_FETCH, 3'd2);
    dev_wdata = 8'h44;
    exp_q.push_back('{is_wr: 1'b1, addr: exp_ptr, data: 8'h44});
    exp_ptr++;
    dma_in_req_n = 1'b0;
    wait_kind(K_FETCH, 3'd7);
    @(negedge clk);
    check(cycle_kind == K_EXEC, "R3 fetch then exec", cycle_kind, K_EXEC);
    wait_kind(K_EXEC, 3'd7);
    @(negedge clk);
    check(cycle_kind == K_IN, "R3 dma after exec", cycle_kind, K_IN);
    dma_in_req_n = 1'b1;
    wait_kind(K_IN, 3'd7);
    @(negedge clk);
    check(ptr == 16'd4, "R7 increment", ptr, 16'd4);

    dma_byte_out();

    // Both requests together.
    dev_wdata = 8'h55;
    exp_q.push_back('{is_wr: 1'b1, addr: exp_ptr, data: 8'h55});
    exp_q.push_back('{is_wr: 1'b0, addr: exp_ptr + 16'd1, data: pat(exp_ptr[7:0] + 8'd1)});
    exp_ptr = exp_ptr + 16'd2;
    dma_in_req_n = 1'b0; dma_out_req_n = 1'b0;
    @(negedge clk);
    while (!((cycle_kind == K_IN || cycle_kind == K_OUT) && phase == 0)) @(negedge clk);
    check(cycle_kind == K_IN, "R4 in before out", cycle_kind, K_IN);
    dma_in_req_n = 1'b1;
    wait_kind(K_OUT, 3'd0);
    dma_out_req_n = 1'b1;
    wait_kind(K_OUT, 3'd7);
    @(negedge clk);

    // Pointer write during a DMA cycle is ignored.
    dev_wdata = 8'h66;
    exp_q.push_back('{is_wr: 1'b1, addr: exp_ptr, data: 8'h66});
    exp_ptr++;
    dma_in_req_n = 1'b0;
    wait_kind(K_IN, 3'd1);
    dma_in_req_n = 1'b1;
    cpu_ptr_we = 1'b1; cpu_ptr_wdata = 16'h1234;
    @(negedge clk);
    cpu_ptr_we = 1'b0;
    wait_kind(K_IN, 3'd7);
    @(negedge clk);
    check(ptr == exp_ptr, "R10 write ignored in dma", ptr, exp_ptr);

    // Pointer write during fetch is accepted; then wrap.
    wait_kind(K_FETCH, 3'd2);
    cpu_ptr_we = 1'b1; cpu_ptr_wdata = 16'hFFFF;
    @(negedge clk);
    cpu_ptr_we = 1'b0;
    check(ptr == 16'hFFFF, "R10 write accepted", ptr, 16'hFFFF);
    exp_ptr = 16'hFFFF;
    dma_byte_in(8'h77);
    check(ptr == 16'h0000, "R7 wrap", ptr, 16'h0000);

    // Pause in the middle of a granted DMA-in cycle.
    dev_wdata = 8'h88;
    exp_q.push_back('{is_wr: 1'b1, addr: exp_ptr, data: 8'h88});
    exp_ptr++;
    dma_in_req_n = 1'b0;
    wait_kind(K_IN, 3'd3);
    dma_in_req_n = 1'b1;
    wait_n = 1'b0;
    p0 = ptr;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (phase != 3'd3 || cycle_kind != K_IN || mem_we || ptr != p0) bad++;
    end
    check(bad == 0, "R2 pause freezes", bad, 0);
    wait_n = 1'b1;
    wait_kind(K_IN, 3'd7);
    @(negedge clk);
    check(ptr == exp_ptr, "R7 step after pause", ptr, exp_ptr);

    // Reset mode from a nonzero pointer.
    clear_n = 1'b0;
    @(negedge clk);
    check(ptr == 0 && phase == 0 && cycle_kind == K_IDLE, "R2 clear", {ptr, 13'd0, cycle_kind}, 32'd0);
    clear_n = 1'b1;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5/R6 all transfers seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule